// File: doc/BRIEF.md
# DMA Error Collector and Interrupt Pulser

This block gathers the error and completion events of a multi-channel DMA engine into one flag register per channel. Events are end of transfer, bus timeout, register read and write parity faults, odd block lengths in double-word mode, and faults reported at the end of an external bus cycle. From those flags it derives the stop line for each channel, a transfer-start block and an ERROR-mode flag. It also drives one active-low interrupt line that pulses for a single clock.

Each channel has two timeout monitors. One watches the handshake request and one watches the ready-wait line. Each monitor counts consecutive asserted cycles, saturates at its limit and restarts from zero whenever its line drops. Software clears flags by writing ones to a clear mask. The block stays in ERROR mode until no flag remains set.

Top module: `dma_err_ctrl`

## Requirements
- R1: After reset, all flags are 0, `irq_no` is 1, and `error_mode_o`, `chan_stop_o` and `xfer_block_o` are 0.
- R2: `eot_i` together with `eot_en_i` for a channel sets that channel's end-of-transfer flag (kind 0) and raises an interrupt pulse, but does not stop the channel. `eot_i` with the enable low has no effect.
- R3: When `hs_req_i` or `rdy_wait_i` of a channel stays high for more than `TMO_LIMIT` (default 256) consecutive cycles, the timeout flag (kind 1) is set on the `TMO_LIMIT+1`-th edge. It stops the channel and interrupts. Holding the line for exactly `TMO_LIMIT` cycles does nothing, and any low cycle restarts the count.
- R4: `rd_par_err_i` sets the read-parity flag (kind 2), stops the channel and interrupts.
- R5: `odd_len_i` sets the odd-length flag (kind 3), stops the channel and interrupts.
- R6: `cycle_end_i` of a channel, while any of `ext_addr_err_i`, `mem_prot_err_i` or `bus_par_err_i` is high, sets the external-fault flag (kind 4) and stops the channel without an interrupt. The external indications are ignored when `cycle_end_i` is low.
- R7: `wr_par_err_i` sets the write-parity flag (kind 5) and raises `xfer_block_o` for that channel. It neither interrupts nor stops the channel.
- R8: The interrupt is `irq_no` low for exactly one clock, on the edge that registers the event. Several interrupting flags set on the same edge give only one pulse.
- R9: A pulse is produced only when an interrupting flag that was clear becomes set. Repeating an event whose flag is already set gives no pulse.
- R10: `irq_no` is low only while `error_mode_o` is 1. `error_mode_o` is 1 whenever any flag is set and drops only once every flag is cleared.
- R11: Flag bit `ch*6+kind` of `err_flags_o` is cleared by writing 1 to the same bit of `flag_clr_i`. A set event on the same edge wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| eot_i | input | N_CH | End-of-transfer event per channel |
| eot_en_i | input | N_CH | End-of-transfer status enable per channel |
| hs_req_i | input | N_CH | Handshake request held, per channel |
| rdy_wait_i | input | N_CH | Ready-wait line held, per channel |
| rd_par_err_i | input | N_CH | Parity fault on register read |
| wr_par_err_i | input | N_CH | Parity fault on register write |
| odd_len_i | input | N_CH | Odd block length in double-word mode |
| cycle_end_i | input | N_CH | External cycle end, owning channel |
| ext_addr_err_i | input | 1 | External address fault |
| mem_prot_err_i | input | 1 | Memory protection fault |
| bus_par_err_i | input | 1 | External bus parity fault |
| flag_clr_i | input | N_CH*6 | Write-one-to-clear mask, bit ch*6+kind |
| err_flags_o | output | N_CH*6 | Flags, bit ch*6+kind |
| chan_stop_o | output | N_CH | Channel halted by kinds 1-4 |
| xfer_block_o | output | N_CH | Transfer start blocked by kind 5 |
| error_mode_o | output | 1 | ERROR mode |
| irq_no | output | 1 | Interrupt pulse, active low |

## Verification
Every flag, stop, block and interrupt result shows up on the first rising edge after the event is presented. The one exception is the timeout, which appears on the 257th consecutive held edge. The interrupt returns high on the edge after that. The bench changes inputs 1 ns after a rising edge and checks at the same offset after the edge where the result is due. It always checks the interrupt on two consecutive samples, so a stretched pulse or a second pulse is caught. For timeouts the bench counts edges exactly: it holds a line for 256 edges and expects no flag, then for 257 edges and expects the flag, and it also drops the line once mid-count.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;
  localparam int unsigned NK = 6;

  typedef enum logic [2:0] {
    K_EOT  = 3'd0,
    K_TMO  = 3'd1,
    K_RPAR = 3'd2,
    K_ODD  = 3'd3,
    K_EXT  = 3'd4,
    K_WPAR = 3'd5
  } err_kind_e;

  localparam logic [NK-1:0] IRQ_MASK   = 6'b00_1111;
  localparam logic [NK-1:0] STOP_MASK  = 6'b01_1110;
  localparam logic [NK-1:0] BLOCK_MASK = 6'b10_0000;
endpackage

// File: rtl/dma_err_tmo.sv
module dma_err_tmo #(
  parameter int unsigned LIMIT = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic tmo_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CMAX = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!line_i)       cnt_q <= '0;
    else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
  end

  // fires on every held cycle beyond LIMIT
  assign tmo_o = line_i && (cnt_q == CMAX);

  a_r3_cnt_saturates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CMAX);
  a_r3_fire_needs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_o |-> $past(line_i));
endmodule

// File: rtl/dma_err_chan.sv
module dma_err_chan
  import dma_err_pkg::*;
#(
  parameter int unsigned TMO_LIMIT = 256
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          eot_i,
  input  logic          eot_en_i,
  input  logic          hs_req_i,
  input  logic          rdy_wait_i,
  input  logic          rd_par_err_i,
  input  logic          wr_par_err_i,
  input  logic          odd_len_i,
  input  logic          cycle_end_i,
  input  logic          ext_any_i,
  input  logic [NK-1:0] clr_i,
  output logic [NK-1:0] flags_o,
  output logic          any_nxt_o,
  output logic          irq_evt_o,
  output logic          stop_o,
  output logic          block_o
);
  logic [1:0]    mon_line, mon_tmo;
  logic [NK-1:0] set_vec, flags_q, flags_nxt;

  assign mon_line = {rdy_wait_i, hs_req_i};

  for (genvar m = 0; m < 2; m++) begin : g_mon
    dma_err_tmo #(.LIMIT(TMO_LIMIT)) u_tmo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .line_i (mon_line[m]),
      .tmo_o  (mon_tmo[m])
    );
  end

  always_comb begin
    set_vec                 = '0;
    set_vec[int'(K_EOT)]    = eot_i && eot_en_i;
    set_vec[int'(K_TMO)]    = |mon_tmo;
    set_vec[int'(K_RPAR)]   = rd_par_err_i;
    set_vec[int'(K_ODD)]    = odd_len_i;
    set_vec[int'(K_EXT)]    = cycle_end_i && ext_any_i;
    set_vec[int'(K_WPAR)]   = wr_par_err_i;
  end

  // set wins over a clear on the same edge
  assign flags_nxt = (flags_q & ~clr_i) | set_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_nxt;
  end

  assign flags_o   = flags_q;
  assign any_nxt_o = |flags_nxt;
  assign irq_evt_o = |(set_vec & ~flags_q & IRQ_MASK);
  assign stop_o    = |(flags_q & STOP_MASK);
  assign block_o   = |(flags_q & BLOCK_MASK);

  a_r11_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_vec != '0) |=> ((flags_q & $past(set_vec)) == $past(set_vec)));
  a_r11_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_vec) != '0) |=> ((flags_q & $past(clr_i & ~set_vec)) == '0));
  a_r2_eot_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!eot_en_i && !flags_q[int'(K_EOT)] && !clr_i[int'(K_EOT)]) |=> !flags_q[int'(K_EOT)]);
endmodule

// File: rtl/dma_err_irq_gen.sv
module dma_err_irq_gen #(
  parameter int unsigned N_CH = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] evt_i,
  input  logic [N_CH-1:0] any_nxt_i,
  output logic            irq_no,
  output logic            err_mode_o
);
  logic irq_n_q, mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_n_q <= 1'b1;
      mode_q  <= 1'b0;
    end else begin
      irq_n_q <= ~(|evt_i);   // any number of events -> one low clock
      mode_q  <= |any_nxt_i;
    end
  end

  assign irq_no     = irq_n_q;
  assign err_mode_o = mode_q;

  a_r10_irq_in_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> err_mode_o);
  a_r9_pulse_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no |-> $past(|evt_i));
endmodule

// File: rtl/dma_err_ctrl.sv
module dma_err_ctrl
  import dma_err_pkg::*;
#(
  parameter int unsigned N_CH      = 4,
  parameter int unsigned TMO_LIMIT = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CH-1:0]    eot_i,
  input  logic [N_CH-1:0]    eot_en_i,
  input  logic [N_CH-1:0]    hs_req_i,
  input  logic [N_CH-1:0]    rdy_wait_i,
  input  logic [N_CH-1:0]    rd_par_err_i,
  input  logic [N_CH-1:0]    wr_par_err_i,
  input  logic [N_CH-1:0]    odd_len_i,
  input  logic [N_CH-1:0]    cycle_end_i,
  input  logic               ext_addr_err_i,
  input  logic               mem_prot_err_i,
  input  logic               bus_par_err_i,
  input  logic [N_CH*6-1:0]  flag_clr_i,
  output logic [N_CH*6-1:0]  err_flags_o,
  output logic [N_CH-1:0]    chan_stop_o,
  output logic [N_CH-1:0]    xfer_block_o,
  output logic               error_mode_o,
  output logic               irq_no
);
  localparam int unsigned FW = N_CH * NK;

  logic            ext_any;
  logic [N_CH-1:0] irq_evt, any_nxt;

  assign ext_any = ext_addr_err_i | mem_prot_err_i | bus_par_err_i;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dma_err_chan #(.TMO_LIMIT(TMO_LIMIT)) u_chan (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .eot_i        (eot_i[c]),
      .eot_en_i     (eot_en_i[c]),
      .hs_req_i     (hs_req_i[c]),
      .rdy_wait_i   (rdy_wait_i[c]),
      .rd_par_err_i (rd_par_err_i[c]),
      .wr_par_err_i (wr_par_err_i[c]),
      .odd_len_i    (odd_len_i[c]),
      .cycle_end_i  (cycle_end_i[c]),
      .ext_any_i    (ext_any),
      .clr_i        (flag_clr_i[c*NK +: NK]),
      .flags_o      (err_flags_o[c*NK +: NK]),
      .any_nxt_o    (any_nxt[c]),
      .irq_evt_o    (irq_evt[c]),
      .stop_o       (chan_stop_o[c]),
      .block_o      (xfer_block_o[c])
    );
  end

  dma_err_irq_gen #(.N_CH(N_CH)) u_irq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (irq_evt),
    .any_nxt_i  (any_nxt),
    .irq_no     (irq_no),
    .err_mode_o (error_mode_o)
  );

  a_r10_mode_tracks_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_mode_o == (err_flags_o != {FW{1'b0}}));
  a_r7_block_no_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_block_o[0]) && !$past(rd_par_err_i[0] | odd_len_i[0] | cycle_end_i[0] | hs_req_i[0] | rdy_wait_i[0])
      |-> (chan_stop_o[0] == $past(chan_stop_o[0])));
endmodule

// File: tb/dma_err_ctrl_test.sv
`timescale 1ns/1ps
module dma_err_ctrl_test;
  localparam int N = 4;
  localparam int K = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] eot = '0, eot_en = '0, hs_req = '0, rdy_wait = '0;
  logic [N-1:0] rd_par = '0, wr_par = '0, odd_len = '0, cyc_end = '0;
  logic ext_addr = 1'b0, mem_prot = 1'b0, bus_par = 1'b0;
  logic [N*K-1:0] clr = '0;
  logic [N*K-1:0] flags;
  logic [N-1:0] stop, block;
  logic mode, irq_n;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_err_ctrl #(.N_CH(N), .TMO_LIMIT(256)) uut (
    .clk_i(clk), .rst_ni(rst_n), .eot_i(eot), .eot_en_i(eot_en),
    .hs_req_i(hs_req), .rdy_wait_i(rdy_wait), .rd_par_err_i(rd_par),
    .wr_par_err_i(wr_par), .odd_len_i(odd_len), .cycle_end_i(cyc_end),
    .ext_addr_err_i(ext_addr), .mem_prot_err_i(mem_prot), .bus_par_err_i(bus_par),
    .flag_clr_i(clr), .err_flags_o(flags), .chan_stop_o(stop),
    .xfer_block_o(block), .error_mode_o(mode), .irq_no(irq_n)
  );

  function automatic logic [N*K-1:0] fb(input int ch, input int k);
    fb = '0;
    fb[ch*K + k] = 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic clear_all();
    clr = '1; tick(); clr = '0;
    chk("R11 all cleared flags", 32'(flags), 32'h0);
    chk("R10 mode left", 32'(mode), 32'h0);
  endtask

  task automatic t_reset();
    chk("R1 flags", 32'(flags), 0);
    chk("R1 irq_n", 32'(irq_n), 1);
    chk("R1 mode", 32'(mode), 0);
    chk("R1 stop", 32'(stop), 0);
    chk("R1 block", 32'(block), 0);
  endtask

  task automatic t_eot();
    eot[1] = 1; eot_en[1] = 0; tick(); eot = '0;
    chk("R2 eot disabled flags", 32'(flags), 0);
    chk("R2 eot disabled irq", 32'(irq_n), 1);
    eot[1] = 1; eot_en[1] = 1; tick(); eot = '0; eot_en = '0;
    chk("R2 eot flag", 32'(flags), 32'(fb(1, 0)));
    chk("R2 eot irq low", 32'(irq_n), 0);
    chk("R2 eot no stop", 32'(stop), 0);
    chk("R10 mode on", 32'(mode), 1);
    tick();
    chk("R8 irq one clock", 32'(irq_n), 1);
    clear_all();
  endtask

  task automatic t_timeout();
    hs_req[2] = 1; repeat (256) tick(); hs_req[2] = 0;
    chk("R3 256 held no flag", 32'(flags), 0);
    tick();
    chk("R3 after drop no flag", 32'(flags), 0);
    hs_req[2] = 1; repeat (200) tick(); hs_req[2] = 0; tick();
    hs_req[2] = 1; repeat (200) tick(); hs_req[2] = 0;
    chk("R3 restart on drop", 32'(flags), 0);
    tick();
    hs_req[2] = 1; repeat (257) tick();
    chk("R3 257 held flag", 32'(flags), 32'(fb(2, 1)));
    chk("R3 stop", 32'(stop), 32'h4);
    chk("R3 irq low", 32'(irq_n), 0);
    hs_req[2] = 0; tick();
    chk("R8 timeout irq one clock", 32'(irq_n), 1);
    rdy_wait[0] = 1; repeat (257) tick(); rdy_wait[0] = 0;
    chk("R3 ready timeout", 32'(flags), 32'(fb(2, 1) | fb(0, 1)));
    chk("R3 ready irq", 32'(irq_n), 0);
    tick();
    clear_all();
  endtask

  task automatic t_rd_odd();
    rd_par[3] = 1; tick(); rd_par = '0;
    chk("R4 rd parity flag", 32'(flags), 32'(fb(3, 2)));
    chk("R4 stop", 32'(stop), 32'h8);
    chk("R4 irq", 32'(irq_n), 0);
    tick();
    odd_len[0] = 1; tick(); odd_len = '0;
    chk("R5 odd flag", 32'(flags), 32'(fb(3, 2) | fb(0, 3)));
    chk("R5 stop", 32'(stop), 32'h9);
    chk("R5 irq", 32'(irq_n), 0);
    tick();
    clear_all();
    chk("R11 stop released", 32'(stop), 0);
  endtask

  task automatic t_ext();
    ext_addr = 1; mem_prot = 1; bus_par = 1; tick();
    ext_addr = 0; mem_prot = 0; bus_par = 0;
    chk("R6 no cycle end ignored", 32'(flags), 0);
    cyc_end[1] = 1; mem_prot = 1; tick(); cyc_end = '0; mem_prot = 0;
    chk("R6 ext flag", 32'(flags), 32'(fb(1, 4)));
    chk("R6 stop", 32'(stop), 32'h2);
    chk("R6 no irq", 32'(irq_n), 1);
    chk("R10 mode by ext", 32'(mode), 1);
    cyc_end[2] = 1; bus_par = 1; tick(); cyc_end = '0; bus_par = 0;
    chk("R6 bus parity flag", 32'(flags), 32'(fb(1, 4) | fb(2, 4)));
    chk("R6 bus parity no irq", 32'(irq_n), 1);
    clear_all();
  endtask

  task automatic t_wr_par();
    wr_par[0] = 1; tick(); wr_par = '0;
    chk("R7 wr parity flag", 32'(flags), 32'(fb(0, 5)));
    chk("R7 block", 32'(block), 1);
    chk("R7 no stop", 32'(stop), 0);
    chk("R7 no irq", 32'(irq_n), 1);
    clear_all();
    chk("R7 block released", 32'(block), 0);
  endtask

  task automatic t_simul_repeat();
    rd_par[0] = 1; odd_len[1] = 1; eot[2] = 1; eot_en[2] = 1; tick();
    rd_par = '0; odd_len = '0; eot = '0; eot_en = '0;
    chk("R8 simultaneous flags", 32'(flags), 32'(fb(0, 2) | fb(1, 3) | fb(2, 0)));
    chk("R8 single pulse low", 32'(irq_n), 0);
    tick();
    chk("R8 single pulse ends", 32'(irq_n), 1);
    rd_par[0] = 1; tick(); rd_par = '0;
    chk("R9 repeat no pulse", 32'(irq_n), 1);
    odd_len[0] = 1; tick(); odd_len = '0;
    chk("R9 new flag pulse", 32'(irq_n), 0);
    tick();
    clr = fb(0, 2); tick(); clr = '0;
    chk("R11 partial clear", 32'(flags), 32'(fb(0, 3) | fb(1, 3) | fb(2, 0)));
    chk("R11 stop held by odd", 32'(stop), 32'h3);
    chk("R10 mode held", 32'(mode), 1);
    clr = fb(3, 2); rd_par[3] = 1; tick(); clr = '0; rd_par = '0;
    chk("R11 set wins", 32'(flags[3*K+2]), 1);
    tick();
    clr = '1 ^ fb(2, 0); tick(); clr = '0;
    chk("R10 mode until last", 32'(mode), 1);
    clear_all();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    tick();
    t_eot();
    t_timeout();
    t_rd_odd();
    t_ext();
    t_wr_par();
    t_simul_repeat();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule